// File: doc/BRIEF.md
# Preemptive Channel Arbiter

This block chooses which of a set of transfer channels gets the transfer engine next. Channels sit in equal-sized groups. Two independent mode inputs select how the choice is made at each level: by fixed priority or by round-robin. The group is chosen first and then a channel inside that group. One channel holds the grant at a time. A grant ends when the engine reports that the channel has finished one iteration of its outer loop.

When both levels use fixed priority, a pending channel of higher priority can interrupt a running channel whose preempt-enable bit is set. The interrupted channel is parked in a single save slot and keeps its active flag. The interrupting channel runs one iteration and cannot itself be interrupted. The parked channel is then handed back the grant.

The controller is one state machine. Its states are IDLE, ARB_A, ARB_B, RUN, PRE_A, PRE_B, PRUN and RESUME. The transitions are as follows:
- IDLE goes to ARB_A when any request is eligible.
- ARB_A latches the winner and goes to ARB_B, or goes back to IDLE if nothing is eligible.
- ARB_B commits the grant and goes to RUN.
- RUN goes to IDLE on done. Without done, it goes to PRE_A on a preemption hit, where the running channel is saved.
- PRE_A re-checks the hit and latches the winner, then goes to PRE_B. If the hit is gone it goes to RESUME.
- PRE_B commits the preemptor and goes to PRUN.
- PRUN goes to RESUME on done.
- RESUME restores the saved channel and goes to RUN.

Top module: `pcha_top`

## Requirements
- R1: After reset, gnt_valid, suspended and resume are 0 and active is all zeros.
- R2: With both modes fixed (grp_rr=0, ch_rr=0), the winner is the eligible channel with the highest group priority. Among channels of that group, the one with the highest channel priority wins. Larger numbers mean higher priority. Channel number = group*CPG + index in group.
- R3: Arbitration takes two cycles. If a request is first sampled in IDLE at clock edge 1, gnt_valid is still 0 after edge 2 and is 1 after edge 3.
- R4: With ch_rr=1, channel priorities are ignored. Inside a group the search starts at the index after the channel last granted in that group, wrapping around. The start is 0 after reset.
- R5: With grp_rr=1, group priorities are ignored. Groups are searched starting after the group last granted, wrapping around. The start is group 0 after reset.
- R6: A channel's active bit is set when it is granted and cleared on the edge where done is sampled high during its grant.
- R7: In RUN with both modes fixed, a preemption starts when the running channel's pre_en bit is 1 and an eligible channel has a strictly higher {group priority, channel priority}. suspended rises on the next edge, with susp_ch set to the running channel. The preemptor is granted two edges later.
- R8: While suspended is 1, the saved channel's active bit stays 1.
- R9: The edge that samples done during a preemptor's grant clears its active bit and raises resume for one cycle. On the next edge the saved channel holds the grant again.
- R10: No preemption occurs if either mode is round-robin, if the running channel's pre_en bit is 0, or if no eligible channel has a higher priority.
- R11: A preempting channel is never preempted, and at most two active bits are set at once.
- R12: A channel whose active bit is set is not eligible, so a request held by the running channel neither re-grants it nor duplicates its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCH | Per-channel service request, level |
| ch_prio | input | NCH*PW | Channel priority, channel i at bits [i*PW +: PW] |
| grp_prio | input | NGRP*GPW | Group priority, group g at bits [g*GPW +: GPW] |
| pre_en | input | NCH | Per-channel permission to be preempted |
| grp_rr | input | 1 | 1 = round-robin between groups |
| ch_rr | input | 1 | 1 = round-robin inside a group |
| done | input | 1 | The granted channel finished one loop iteration |
| gnt_valid | output | 1 | A channel holds the grant (RUN or PRUN) |
| gnt_ch | output | CHW | Granted channel number |
| active | output | NCH | Per-channel active flag |
| suspended | output | 1 | A channel is parked by preemption |
| susp_ch | output | CHW | Parked channel number |
| resume | output | 1 | One-cycle pulse while the parked channel is restored |

## Verification
The assertions assume three things about the inputs:
- Priorities within each comparison are distinct.
- The mode inputs change only while the block is idle.
- done is raised only while a grant is valid.

The directed tasks follow these rules. They reset before each scenario and set the modes and priorities in the idle state. They assign distinct channel and group priorities. They pulse done only after gnt_valid has been observed high.

// File: rtl/pcha_pkg.sv
package pcha_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB_A,
        ST_ARB_B,
        ST_RUN,
        ST_PRE_A,
        ST_PRE_B,
        ST_PRUN,
        ST_RESUME
    } pcha_state_e;
endpackage

// File: rtl/pcha_pick.sv
// Selects one requester out of N, either by highest priority or by
// round-robin search starting from ptr.
module pcha_pick #(
    parameter int N  = 4,
    parameter int PW = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    input  logic            rr_mode,
    input  logic [IW-1:0]   ptr,
    output logic            any,
    output logic [IW-1:0]   idx
);
    logic [IW-1:0] cand;
    logic [PW-1:0] best;
    logic          found;

    always_comb begin
        any   = |req;
        idx   = '0;
        best  = '0;
        found = 1'b0;
        cand  = '0;
        if (rr_mode) begin
            // downward scan so the smallest offset from ptr is kept last
            for (int k = N - 1; k >= 0; k--) begin
                cand = ptr + IW'(k);
                if (req[cand]) idx = cand;
            end
        end else begin
            for (int c = 0; c < N; c++) begin
                if (req[c] && (!found || prio[c*PW +: PW] > best)) begin
                    found = 1'b1;
                    best  = prio[c*PW +: PW];
                    idx   = IW'(c);
                end
            end
        end
    end
endmodule

// File: rtl/pcha_rr_ptrs.sv
// Round-robin start pointers: one for groups, one per group for channels.
module pcha_rr_ptrs #(
    parameter int NGRP = 2,
    parameter int GW   = 1,
    parameter int CW   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic [GW-1:0]      win_g,
    input  logic [CW-1:0]      win_c,
    output logic [GW-1:0]      gptr,
    output logic [NGRP*CW-1:0] cptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)   gptr <= '0;
        else if (upd) gptr <= win_g + GW'(1);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n)
                cptr[g*CW +: CW] <= '0;
            else if (upd && win_g == GW'(g))
                cptr[g*CW +: CW] <= win_c + CW'(1);
        end
    end
endmodule

// File: rtl/pcha_top.sv
module pcha_top
    import pcha_pkg::*;
#(
    parameter int NGRP = 2,
    parameter int CPG  = 4,
    parameter int PW   = 4,
    parameter int GPW  = 2,
    localparam int NCH = NGRP * CPG,
    localparam int GW  = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int CW  = (CPG > 1) ? $clog2(CPG) : 1,
    localparam int CHW = GW + CW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      req,
    input  logic [NCH*PW-1:0]   ch_prio,
    input  logic [NGRP*GPW-1:0] grp_prio,
    input  logic [NCH-1:0]      pre_en,
    input  logic                grp_rr,
    input  logic                ch_rr,
    input  logic                done,
    output logic                gnt_valid,
    output logic [CHW-1:0]      gnt_ch,
    output logic [NCH-1:0]      active,
    output logic                suspended,
    output logic [CHW-1:0]      susp_ch,
    output logic                resume
);
    localparam int KW = GPW + PW;

    pcha_state_e        state, nxt;
    logic [NCH-1:0]     act_q;
    logic [CHW-1:0]     run_q, sav_q, win_q;
    logic [NCH-1:0]     eligible;
    logic [NGRP-1:0]    g_any;
    logic [CW-1:0]      g_idx [NGRP];
    logic [GW-1:0]      gptr, cand_g;
    logic [NGRP*CW-1:0] cptr;
    logic               cand_any;
    logic [CHW-1:0]     cand_ch;
    logic [KW-1:0]      cand_key, run_key;
    logic               fixed_all, preempt_hit, grant_upd;

    assign eligible = req & ~act_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_chan
        pcha_pick #(.N(CPG), .PW(PW), .IW(CW)) u_pick (
            .req     (eligible[g*CPG +: CPG]),
            .prio    (ch_prio[g*CPG*PW +: CPG*PW]),
            .rr_mode (ch_rr),
            .ptr     (cptr[g*CW +: CW]),
            .any     (g_any[g]),
            .idx     (g_idx[g])
        );
    end

    pcha_pick #(.N(NGRP), .PW(GPW), .IW(GW)) u_grp (
        .req     (g_any),
        .prio    (grp_prio),
        .rr_mode (grp_rr),
        .ptr     (gptr),
        .any     (cand_any),
        .idx     (cand_g)
    );

    assign cand_ch   = {cand_g, g_idx[cand_g]};
    assign grant_upd = (state == ST_ARB_B) || (state == ST_PRE_B);

    pcha_rr_ptrs #(.NGRP(NGRP), .GW(GW), .CW(CW)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (grant_upd),
        .win_g (win_q[CHW-1:CW]),
        .win_c (win_q[CW-1:0]),
        .gptr  (gptr),
        .cptr  (cptr)
    );

    // {group priority, channel priority} comparison keys
    always_comb begin
        cand_key = {grp_prio[int'(cand_ch[CHW-1:CW])*GPW +: GPW],
                    ch_prio[int'(cand_ch)*PW +: PW]};
        run_key  = {grp_prio[int'(run_q[CHW-1:CW])*GPW +: GPW],
                    ch_prio[int'(run_q)*PW +: PW]};
    end

    assign fixed_all   = !grp_rr && !ch_rr;
    assign preempt_hit = fixed_all && pre_en[run_q] && cand_any
                         && (cand_key > run_key);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cand_any) nxt = ST_ARB_A;
            ST_ARB_A:  nxt = cand_any ? ST_ARB_B : ST_IDLE;
            ST_ARB_B:  nxt = ST_RUN;
            ST_RUN: begin
                if (done)             nxt = ST_IDLE;
                else if (preempt_hit) nxt = ST_PRE_A;
            end
            ST_PRE_A:  nxt = preempt_hit ? ST_PRE_B : ST_RESUME;
            ST_PRE_B:  nxt = ST_PRUN;
            ST_PRUN:   if (done) nxt = ST_RESUME;
            ST_RESUME: nxt = ST_RUN;
        endcase
    end

    // channel registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            run_q <= '0;
            sav_q <= '0;
            win_q <= '0;
        end else begin
            unique case (state)
                ST_ARB_A, ST_PRE_A: win_q <= cand_ch;
                ST_ARB_B, ST_PRE_B: begin
                    run_q        <= win_q;
                    act_q[win_q] <= 1'b1;
                end
                ST_RUN: begin
                    if (done)             act_q[run_q] <= 1'b0;
                    else if (preempt_hit) sav_q        <= run_q;
                end
                ST_PRUN:   if (done) act_q[run_q] <= 1'b0;
                ST_RESUME: run_q <= sav_q;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        gnt_valid = (state == ST_RUN) || (state == ST_PRUN);
        gnt_ch    = run_q;
        active    = act_q;
        suspended = (state == ST_PRE_A) || (state == ST_PRE_B) || (state == ST_PRUN);
        susp_ch   = sav_q;
        resume    = (state == ST_RESUME);
    end
endmodule

// File: rtl/pcha_checker.sv
module pcha_checker #(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           grp_rr,
    input logic           ch_rr,
    input logic           gnt_valid,
    input logic [CHW-1:0] gnt_ch,
    input logic [NCH-1:0] active,
    input logic           suspended,
    input logic [CHW-1:0] susp_ch,
    input logic           resume
);
    p_grant_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> active[gnt_ch]);

    p_parked_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> active[susp_ch]);

    p_resume_regrant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (gnt_valid && gnt_ch == $past(susp_ch)));

    p_fixed_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(!grp_rr && !ch_rr));

    p_depth_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active) <= 2);

    p_single_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && $past(suspended)) |-> $stable(susp_ch));
endmodule

bind pcha_top pcha_checker #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_rr    (grp_rr),
    .ch_rr     (ch_rr),
    .gnt_valid (gnt_valid),
    .gnt_ch    (gnt_ch),
    .active    (active),
    .suspended (suspended),
    .susp_ch   (susp_ch),
    .resume    (resume)
);

// File: tb/pcha_top_test.sv
module pcha_top_test;
    localparam int NCH = 8;
    localparam int PW  = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] req;
    logic [31:0]    ch_prio;
    logic [3:0]     grp_prio;
    logic [NCH-1:0] pre_en;
    logic           grp_rr, ch_rr, done;
    logic           gnt_valid, suspended, resume;
    logic [2:0]     gnt_ch, susp_ch;
    logic [NCH-1:0] active;
    logic [3:0]     cp [NCH];
    logic [1:0]     gp [2];
    int             n_run = 0, n_fail = 0;

    always #2ns clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) ch_prio[i*PW +: PW] = cp[i];
        grp_prio = {gp[1], gp[0]};
    end

    pcha_top uut (
        .clk(clk), .rst_n(rst_n), .req(req), .ch_prio(ch_prio),
        .grp_prio(grp_prio), .pre_en(pre_en), .grp_rr(grp_rr),
        .ch_rr(ch_rr), .done(done), .gnt_valid(gnt_valid),
        .gnt_ch(gnt_ch), .active(active), .suspended(suspended),
        .susp_ch(susp_ch), .resume(resume)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic do_reset(input logic g_rr, input logic c_rr, input logic [NCH-1:0] pe);
        @(negedge clk);
        rst_n = 1'b0; req = '0; done = 1'b0;
        grp_rr = g_rr; ch_rr = c_rr; pre_en = pe;
        cp[0] = 4'd3; cp[1] = 4'd7; cp[2] = 4'd5; cp[3] = 4'd9;
        cp[4] = 4'd2; cp[5] = 4'd6; cp[6] = 4'd4; cp[7] = 4'd8;
        gp[0] = 2'd1; gp[1] = 2'd2;
        wait_neg(2);
        rst_n = 1'b1;
        wait_neg(1);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0, '1);
        chk("R1 gnt_valid", 32'(gnt_valid), 0);
        chk("R1 active", 32'(active), 0);
        chk("R1 suspended", 32'(suspended), 0);
        chk("R1 resume", 32'(resume), 0);
    endtask

    task automatic t_fixed();
        do_reset(1'b0, 1'b0, '1);
        req = 8'b0010_0110;                  // ch1, ch2, ch5
        wait_neg(2);
        chk("R3 no grant after two edges", 32'(gnt_valid), 0);
        wait_neg(1);
        chk("R3 grant after three edges", 32'(gnt_valid), 1);
        chk("R2 group 1 wins", 32'(gnt_ch), 5);
        chk("R6 active set", 32'(active), 32'h20);
        wait_neg(4);
        chk("R12 held request no second flag", 32'(active), 32'h20);
        chk("R12 grant unchanged", 32'(gnt_ch), 5);
        req = 8'b0000_0110;
        pulse_done();
        chk("R6 active cleared on done", 32'(active), 0);
        wait_neg(3);
        chk("R2 channel priority in group 0", 32'(gnt_ch), 1);
        req = '0;
        pulse_done();
        pulse_done();                         // done while idle
        wait_neg(3);
        chk("R6 done while idle ignored", 32'(active), 0);
        chk("R6 no grant while idle", 32'(gnt_valid), 0);
    endtask

    task automatic t_rr_chan();
        int exp_seq [5] = '{0, 1, 2, 3, 0};
        do_reset(1'b0, 1'b1, '1);
        req = 8'b0000_1111;
        wait_neg(3);
        foreach (exp_seq[i]) begin
            chk("R4 channel rotation", 32'(gnt_ch), 32'(exp_seq[i]));
            pulse_done();
            wait_neg(3);
        end
        req = 8'b0000_0101;                  // ch0 and ch2; last granted ch1
        pulse_done();
        wait_neg(3);
        chk("R4 search after last granted", 32'(gnt_ch), 2);
        pulse_done();
        wait_neg(3);
        chk("R4 wraparound", 32'(gnt_ch), 0);
        req = '0;
        pulse_done();
    endtask

    task automatic t_rr_group();
        int exp_seq [4] = '{1, 6, 1, 6};
        do_reset(1'b1, 1'b0, '1);
        req = 8'b0100_0010;                  // ch1 (group 0), ch6 (group 1)
        wait_neg(3);
        foreach (exp_seq[i]) begin
            chk("R5 group rotation", 32'(gnt_ch), 32'(exp_seq[i]));
            pulse_done();
            wait_neg(3);
        end
        req = '0;
        pulse_done();
    endtask

    task automatic t_preempt();
        do_reset(1'b0, 1'b0, '1);
        req = 8'b0000_0001;
        wait_neg(3);
        chk("R2 low channel runs", 32'(gnt_ch), 0);
        req = 8'b0010_0000;                  // ch5 outranks ch0
        wait_neg(1);
        chk("R7 suspended rises", 32'(suspended), 1);
        chk("R7 parked channel", 32'(susp_ch), 0);
        chk("R7 grant paused", 32'(gnt_valid), 0);
        chk("R8 parked still active", 32'(active), 32'h01);
        wait_neg(2);
        chk("R7 preemptor granted", 32'(gnt_ch), 5);
        chk("R8 both active", 32'(active), 32'h21);
        req = 8'b1000_0000;                  // ch7 outranks ch5
        wait_neg(4);
        chk("R11 preemptor not preempted", 32'(gnt_ch), 5);
        chk("R11 two active flags", 32'(active), 32'h21);
        pulse_done();
        chk("R9 resume pulse", 32'(resume), 1);
        chk("R9 preemptor flag cleared", 32'(active), 32'h01);
        wait_neg(1);
        chk("R9 parked channel regranted", 32'(gnt_ch), 0);
        chk("R9 grant valid again", 32'(gnt_valid), 1);
        chk("R9 resume one cycle", 32'(resume), 0);
        wait_neg(3);
        chk("R7 second preemption", 32'(gnt_ch), 7);
        chk("R8 flags during second preemption", 32'(active), 32'h81);
        req = '0;
        pulse_done();
        wait_neg(1);
        chk("R9 back to parked", 32'(gnt_ch), 0);
        pulse_done();
        chk("R6 all flags cleared", 32'(active), 0);
    endtask

    task automatic no_preempt_case(input string tag, input logic c_rr,
                                   input logic [NCH-1:0] pe,
                                   input int first, input int second);
        do_reset(1'b0, c_rr, pe);
        req = NCH'(1) << first;
        wait_neg(3);
        req = NCH'(1) << second;
        wait_neg(4);
        chk({"R10 ", tag, " grant kept"}, 32'(gnt_ch), 32'(first));
        chk({"R10 ", tag, " nothing parked"}, 32'(suspended), 0);
        pulse_done();
        wait_neg(3);
        chk({"R10 ", tag, " waits its turn"}, 32'(gnt_ch), 32'(second));
        req = '0;
        pulse_done();
    endtask

    task automatic t_no_preempt();
        no_preempt_case("round-robin mode", 1'b1, '1, 0, 7);
        no_preempt_case("enable clear", 1'b0, 8'hFE, 0, 7);
        no_preempt_case("lower request", 1'b0, '1, 7, 0);
    endtask

    initial begin
        rst_n = 1'b0; req = '0; done = 1'b0;
        grp_rr = 1'b0; ch_rr = 1'b0; pre_en = '0;
        for (int i = 0; i < NCH; i++) cp[i] = '0;
        gp[0] = '0; gp[1] = '0;
        fork
            begin
                t_reset();
                t_fixed();
                t_rr_chan();
                t_rr_group();
                t_preempt();
                t_no_preempt();
            end
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule